// File: doc/BRIEF.md
# I2C Channel-Select Controller with Interrupt Merge

This block is an I2C-bus target that owns one 8-bit control register. The low four bits of that register enable any mix of four downstream bus channels. The upstream SCL and SDA lines are sampled by a faster system clock. The block recognises its own 7-bit address and accepts one data byte per write. A read returns the register together with the live interrupt state. The SCL rate therefore only has to be slow compared with the system clock, and it may drop all the way to zero.

Four active-low interrupt lines from the downstream side are merged into one active-low output. The same lines also appear as read-only flags in the upper half of the byte returned by a read. An asynchronous power-on reset and a synchronised active-low reset input both return the bus engine to idle and switch every channel off. The reset input lets a system recover when a downstream bus is stuck.

Top module: `chsel_switch`

## Requirements
- R1: The block answers only the address formed by the fixed bits 11100 followed by `addr_pins[1]` and `addr_pins[0]`, sent MSB first. The eighth bit after the address is the direction (0 write, 1 read). On a match, SDA is pulled low during the ninth SCL clock. On a mismatch, SDA is never driven until the next START.
- R2: In a write, the data byte sent after the address is acknowledged. Its bits 3..0 become the new enables for channels 3..0 (bit n drives `chan_en[n]`). Its bits 7..4 have no effect.
- R3: `chan_en` stays unchanged while a write is in progress. It takes the written value only at the STOP that ends that write.
- R4: A read returns one byte, MSB first. Bits 3..0 are the current `chan_en`. Bit 4+n is 1 while `irq_n_i[n]` is low. SDA is released after the eighth data bit and stays released through the master's acknowledge bit.
- R5: `irq_n_o` is low while any `irq_n_i` bit is low and high while all four are high. It follows the inputs within three system clocks.
- R6: While `ext_rst_n` is low, the bus engine returns to idle, SDA is released and `chan_en` is cleared within four system clocks. A write that has not yet been committed is discarded. The next full transaction works normally.
- R7: After power-on reset, `chan_en` is 0000, SDA is released and `irq_n_o` reflects the interrupt inputs.
- R8: A second data byte in the same write is not acknowledged. It has no effect on the value committed at STOP.
- R9: A repeated START restarts address decoding. A write that has been acknowledged but not yet committed is kept until the next STOP, so a read after the repeated START still returns the old enables.
- R10: Behaviour does not depend on the SCL rate, as long as each SCL high phase, each SCL low phase and each SDA setup lasts at least six system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than SCL |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_n | input | 1 | External recovery reset, active low, synchronised inside |
| scl_i | input | 1 | Upstream serial clock as seen on the wire |
| sda_i | input | 1 | Upstream serial data as seen on the wire |
| sda_oe | output | 1 | 1 pulls the upstream SDA line low |
| addr_pins | input | 2 | Strapped low address bits |
| irq_n_i | input | 4 | Downstream interrupt requests, active low |
| irq_n_o | output | 1 | Merged interrupt, active low |
| chan_en | output | 4 | Per-channel enables, 1 connects the channel |

## Verification
Several properties are checked on every cycle. The enables may change only in the cycle after a STOP or after the recovery reset. The recovery reset always leaves the enables at zero and SDA released. SDA is driven only inside an acknowledge slot or a read byte, and is free after each STOP. The merged interrupt and the read flags always agree. The bench scenarios cover what needs whole transactions: address matching against the strap pins, the masking of the upper written bits, the bit order of a read, the NACK of an extra byte, commits held across a repeated START, and operation at two SCL speeds.

// File: rtl/chsel_pkg.sv
package chsel_pkg;

  localparam int BYTE_W = 8;
  localparam int NCH    = BYTE_W / 2;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_AACK,
    S_WDAT,
    S_WACK,
    S_RDAT,
    S_RACK,
    S_HOLD
  } sl_state_t;

  // Compare a received 7-bit address with the fixed prefix and strap pins.
  function automatic logic addr_hit(input logic [6:0] rx_addr,
                                    input logic [4:0] prefix,
                                    input logic [1:0] pins);
    return rx_addr == {prefix, pins};
  endfunction

  // Byte returned on a read: active-high interrupt flags above the enables.
  function automatic logic [BYTE_W-1:0] pack_status(input logic [NCH-1:0] en,
                                                    input logic [NCH-1:0] irq_n);
    return {~irq_n, en};
  endfunction

  // Active-low merge: the output is low when any request is low.
  function automatic logic merge_irq_n(input logic [NCH-1:0] irq_n);
    return &irq_n;
  endfunction

endpackage

// File: rtl/chsel_sync.sv
module chsel_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

endmodule

// File: rtl/chsel_bus_cond.sv
module chsel_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic scl_d;
  logic sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  =  scl_s & ~scl_d;
  assign scl_fall  = ~scl_s &  scl_d;
  assign start_evt =  scl_s &  scl_d &  sda_d & ~sda_s;
  assign stop_evt  =  scl_s &  scl_d & ~sda_d &  sda_s;

endmodule

// File: rtl/chsel_target_fsm.sv
module chsel_target_fsm
  import chsel_pkg::*;
#(
  parameter logic [4:0] ADDR_PREFIX = 5'b11100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              sda_s,
  input  logic [1:0]        pins,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              sda_oe,
  output logic              wr_commit,
  output logic [NCH-1:0]    wr_value,
  output logic              drive_window
);

  sl_state_t         st;
  logic [CNT_W-1:0]  cnt;
  logic [6:0]        sh;
  logic [6:0]        tx;
  logic              rd;
  logic              ack_on;
  logic              pending;
  logic [NCH-1:0]    stage;

  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; tx <= '0; rd <= 1'b0;
      ack_on <= 1'b0; pending <= 1'b0; stage <= '0; sda_oe <= 1'b0;
    end else if (srst) begin
      st <= S_IDLE; cnt <= '0; ack_on <= 1'b0; pending <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_evt) begin
      st <= S_ADDR; cnt <= '0; ack_on <= 1'b0; sda_oe <= 1'b0;
    end else if (stop_evt) begin
      st <= S_IDLE; pending <= 1'b0; sda_oe <= 1'b0;
    end else begin
      case (st)
        S_ADDR: if (scl_rise) begin
          sh  <= {sh[5:0], sda_s};
          cnt <= cnt + 1'b1;
          if (cnt == LAST) begin
            if (addr_hit(sh, ADDR_PREFIX, pins)) begin
              st <= S_AACK; rd <= sda_s; ack_on <= 1'b0;
            end else begin
              st <= S_HOLD;
            end
          end
        end
        S_AACK: if (scl_fall) begin
          if (!ack_on) begin
            sda_oe <= 1'b1; ack_on <= 1'b1;
          end else begin
            ack_on <= 1'b0; cnt <= '0;
            if (rd) begin
              tx <= rd_byte[6:0]; sda_oe <= ~rd_byte[7]; st <= S_RDAT;
            end else begin
              sda_oe <= 1'b0; st <= S_WDAT;
            end
          end
        end
        S_WDAT: if (scl_rise) begin
          sh  <= {sh[5:0], sda_s};
          cnt <= cnt + 1'b1;
          if (cnt == LAST) begin
            stage   <= {sh[NCH-2:0], sda_s};
            pending <= 1'b1;
            ack_on  <= 1'b0;
            st      <= S_WACK;
          end
        end
        S_WACK: if (scl_fall) begin
          if (!ack_on) begin
            sda_oe <= 1'b1; ack_on <= 1'b1;
          end else begin
            sda_oe <= 1'b0; ack_on <= 1'b0; st <= S_HOLD;
          end
        end
        S_RDAT: if (scl_fall) begin
          if (cnt == LAST) begin
            sda_oe <= 1'b0; st <= S_RACK;
          end else begin
            sda_oe <= ~tx[6];
            tx     <= {tx[5:0], 1'b0};
            cnt    <= cnt + 1'b1;
          end
        end
        S_RACK: if (scl_rise) st <= S_HOLD;
        default: ;
      endcase
    end
  end

  assign wr_commit    = stop_evt & pending & ~srst;
  assign wr_value     = stage;
  assign drive_window = (st == S_AACK) || (st == S_WACK) || (st == S_RDAT);

endmodule

// File: rtl/chsel_switch.sv
module chsel_switch
  import chsel_pkg::*;
#(
  parameter logic [4:0] ADDR_PREFIX = 5'b11100
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ext_rst_n,
  input  logic           scl_i,
  input  logic           sda_i,
  output logic           sda_oe,
  input  logic [1:0]     addr_pins,
  input  logic [NCH-1:0] irq_n_i,
  output logic           irq_n_o,
  output logic [NCH-1:0] chan_en
);

  logic [1:0]        bus_s;
  logic              ext_s;
  logic [NCH-1:0]    irq_s;
  logic              srst;
  logic              scl_rise, scl_fall, start_evt, stop_evt;
  logic              wr_commit;
  logic [NCH-1:0]    wr_value;
  logic              drive_window;
  logic [BYTE_W-1:0] rd_byte;
  logic [NCH-1:0]    rd_flags;

  chsel_sync #(.W(2), .RST_VAL(2'b11)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(bus_s));

  chsel_sync #(.W(1), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_rst_n), .q(ext_s));

  chsel_sync #(.W(NCH), .RST_VAL({NCH{1'b1}})) u_irq_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_n_i), .q(irq_s));

  assign srst = ~ext_s;

  chsel_bus_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(bus_s[1]), .sda_s(bus_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt));

  assign rd_byte  = pack_status(chan_en, irq_s);
  assign rd_flags = rd_byte[BYTE_W-1:NCH];

  chsel_target_fsm #(.ADDR_PREFIX(ADDR_PREFIX)) u_fsm (
    .clk(clk), .rst_n(rst_n), .srst(srst),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .sda_s(bus_s[0]), .pins(addr_pins), .rd_byte(rd_byte),
    .sda_oe(sda_oe), .wr_commit(wr_commit), .wr_value(wr_value),
    .drive_window(drive_window));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         chan_en <= '0;
    else if (srst)      chan_en <= '0;
    else if (wr_commit) chan_en <= wr_value;
  end

  assign irq_n_o = merge_irq_n(irq_s);

endmodule

// File: rtl/chsel_switch_chk.sv
module chsel_switch_chk
  import chsel_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           srst,
  input logic           stop_evt,
  input logic           sda_oe,
  input logic           drive_window,
  input logic           irq_n_o,
  input logic [NCH-1:0] rd_flags,
  input logic [NCH-1:0] chan_en
);

  // R3: enables move only after a STOP or the recovery reset
  a_r3_commit_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_en) |-> ($past(stop_evt) || $past(srst)));

  // R6: recovery reset clears enables and frees SDA
  a_r6_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (chan_en == '0 && !sda_oe));

  // R4: SDA is driven only in an acknowledge slot or a read byte
  a_r4_drive_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> drive_window);

  // R1: SDA is free in the cycle after a STOP
  a_r1_free_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  // R5: merged output and read flags agree
  a_r5_idle_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n_o |-> rd_flags == '0);

  a_r5_active_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n_o |-> rd_flags != '0);

endmodule

bind chsel_switch chsel_switch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .srst(srst), .stop_evt(stop_evt),
  .sda_oe(sda_oe), .drive_window(drive_window), .irq_n_o(irq_n_o),
  .rd_flags(rd_flags), .chan_en(chan_en));

// File: tb/sim_chsel_switch.sv
module sim_chsel_switch;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_rst_n = 1'b1;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic [1:0] pins = 2'b10;
  logic [3:0] irq_n = 4'hF;
  logic       sda_oe;
  logic       irq_n_o;
  logic [3:0] chan_en;
  wire        sda_line = sda_m & ~sda_oe;

  int n_chk = 0;
  int n_bad = 0;
  int hp = 8;
  bit done = 0;

  always #4 clk = ~clk;

  chsel_switch u0 (
    .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n),
    .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_pins(pins), .irq_n_i(irq_n), .irq_n_o(irq_n_o),
    .chan_en(chan_en));

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic i2c_start;
    wt(2); sda_m = 1'b1; wt(hp); scl = 1'b1; wt(hp); sda_m = 1'b0; wt(hp); scl = 1'b0;
  endtask

  task automatic i2c_stop;
    wt(2); sda_m = 1'b0; wt(hp); scl = 1'b1; wt(hp); sda_m = 1'b1; wt(hp);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      wt(2); sda_m = b[i]; wt(hp); scl = 1'b1; wt(hp); scl = 1'b0;
    end
    wt(2); sda_m = 1'b1; wt(hp); scl = 1'b1; wt(hp / 2);
    ack = !sda_line;
    wt(hp - hp / 2); scl = 1'b0; wt(4);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit nack);
    for (int i = 7; i >= 0; i--) begin
      wt(2); sda_m = 1'b1; wt(hp); scl = 1'b1; wt(hp / 2);
      b[i] = sda_line;
      wt(hp - hp / 2); scl = 1'b0;
    end
    wt(2); sda_m = nack; wt(hp); scl = 1'b1; wt(hp); scl = 1'b0; wt(4);
  endtask

  function automatic logic [7:0] abyte(input logic [1:0] p, input bit rw);
    return {5'b11100, p, rw};
  endfunction

  task automatic write_reg(input logic [7:0] d);
    bit a;
    i2c_start;
    send_byte(abyte(pins, 1'b0), a); chk(a, "R1 write addr ack", a, 1);
    send_byte(d, a);                 chk(a, "R2 data ack", a, 1);
    i2c_stop;
  endtask

  task automatic read_reg(output logic [7:0] v);
    bit a;
    i2c_start;
    send_byte(abyte(pins, 1'b1), a); chk(a, "R1 read addr ack", a, 1);
    recv_byte(v, 1'b1);
    chk(!sda_oe, "R4 released after nack", sda_oe, 0);
    i2c_stop;
  endtask

  task automatic t_reset_state;
    chk(chan_en == 4'h0, "R7 chan_en", chan_en, 0);
    chk(!sda_oe, "R7 sda_oe", sda_oe, 0);
    chk(irq_n_o, "R7 irq_n_o", irq_n_o, 1);
  endtask

  task automatic t_write_commit;
    bit a;
    i2c_start;
    send_byte(abyte(pins, 1'b0), a); chk(a, "R1 addr ack", a, 1);
    send_byte(8'hA5, a);             chk(a, "R2 data ack", a, 1);
    wt(10);
    chk(chan_en == 4'h0, "R3 held before stop", chan_en, 0);
    i2c_stop;
    chk(chan_en == 4'h5, "R2 R3 commit low nibble", chan_en, 5);
  endtask

  task automatic t_read_back;
    logic [7:0] v;
    irq_n = 4'b1010; wt(4);
    read_reg(v);
    chk(v == 8'h55, "R4 read byte", v, 8'h55);
    irq_n = 4'b1111; wt(4);
    read_reg(v);
    chk(v == 8'h05, "R4 read no flags", v, 8'h05);
  endtask

  task automatic t_addr_mismatch;
    bit a;
    i2c_start;
    send_byte(abyte(2'b01, 1'b0), a); chk(!a, "R1 wrong pins nack", a, 0);
    send_byte(8'h0F, a);              chk(!a, "R1 data after mismatch", a, 0);
    i2c_stop;
    i2c_start;
    send_byte(8'hC4, a);              chk(!a, "R1 wrong prefix nack", a, 0);
    i2c_stop;
    chk(chan_en == 4'h5, "R1 no change on mismatch", chan_en, 5);
  endtask

  task automatic t_irq_merge;
    logic [3:0] pat [5] = '{4'hF, 4'hE, 4'h7, 4'h0, 4'hF};
    for (int i = 0; i < 5; i++) begin
      irq_n = pat[i]; wt(3);
      chk(irq_n_o == &pat[i], "R5 merged irq", irq_n_o, &pat[i]);
    end
  endtask

  task automatic t_extra_byte;
    bit a;
    i2c_start;
    send_byte(abyte(pins, 1'b0), a); chk(a, "R8 addr ack", a, 1);
    send_byte(8'h03, a);             chk(a, "R8 first ack", a, 1);
    send_byte(8'h0C, a);             chk(!a, "R8 second nack", a, 0);
    i2c_stop;
    chk(chan_en == 4'h3, "R8 first byte wins", chan_en, 3);
  endtask

  task automatic t_repeated_start;
    bit a;
    logic [7:0] v;
    i2c_start;
    send_byte(abyte(pins, 1'b0), a); chk(a, "R9 addr ack", a, 1);
    send_byte(8'h09, a);             chk(a, "R9 data ack", a, 1);
    i2c_start;
    send_byte(abyte(pins, 1'b1), a); chk(a, "R9 restart addr ack", a, 1);
    recv_byte(v, 1'b1);
    chk(v == 8'h03, "R9 old value before stop", v, 3);
    i2c_stop;
    chk(chan_en == 4'h9, "R9 commit at stop", chan_en, 9);
  endtask

  task automatic t_ext_reset;
    bit a;
    logic [7:0] v;
    ext_rst_n = 1'b0; wt(4);
    chk(chan_en == 4'h0, "R6 cleared", chan_en, 0);
    ext_rst_n = 1'b1; wt(4);
    i2c_start;
    send_byte(abyte(pins, 1'b0), a);
    send_byte(8'h0F, a); chk(a, "R6 data ack", a, 1);
    ext_rst_n = 1'b0; wt(4);
    chk(!sda_oe, "R6 sda released", sda_oe, 0);
    ext_rst_n = 1'b1; wt(4);
    i2c_stop;
    chk(chan_en == 4'h0, "R6 pending dropped", chan_en, 0);
    write_reg(8'h06);
    read_reg(v);
    chk(v == 8'h06, "R6 works after reset", v, 6);
  endtask

  task automatic t_speed;
    logic [7:0] v;
    pins = 2'b01;
    hp = 20;
    write_reg(8'h0A); read_reg(v);
    chk(v == 8'h0A, "R10 slow scl", v, 8'h0A);
    hp = 6;
    write_reg(8'h0C); read_reg(v);
    chk(v == 8'h0C, "R10 fast scl", v, 8'h0C);
    chk(chan_en == 4'hC, "R10 enables", chan_en, 8'hC);
  endtask

  initial begin : watchdog
    for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    wt(3); rst_n = 1'b1; wt(5);
    t_reset_state;
    t_write_commit;
    t_read_back;
    t_addr_mismatch;
    t_irq_merge;
    t_extra_byte;
    t_repeated_start;
    t_ext_reset;
    t_speed;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule